// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a small direct-mapped cache between a byte-wide requester and a slower backing memory. Each set holds exactly one line, made of a valid flag, a tag and a multi-byte block. A read that finds its block present returns the byte on the cycle after it is accepted. A read that misses fetches the whole block from memory, installs it in the indexed line in place of whatever was there, and returns the requested byte.

Every write is forwarded to memory straight away. A write that hits also updates the cached byte, so cache and memory never disagree and no dirty state is kept. A write that misses leaves the cache untouched. The requester can have only one request in flight, and the ready output stays low while a block fill or a memory write is pending. Two running counters record how many completed requests hit and how many missed, so a miss rate can be derived as misses over their sum.

Capacity in data bytes is sets times block bytes, with one line per set. The default shape is 4-bit byte addresses, 2-byte blocks and 4 sets.

Top module: `dmc_cache`

## Requirements
- R1: The byte address is split from the top down into tag bits, set-index bits (`req_addr[OFF_W +: IDX_W]`) and block-offset bits (`req_addr[OFF_W-1:0]`). A fill reads memory at the block-aligned address, with the offset bits zero. In the returned line, byte k sits at bits [8k+7:8k].
- R2: After reset every line is invalid, both counters are zero, `req_ready` is 1 and no memory request is active, so the first access to any set misses.
- R3: A read whose set holds a valid line with a matching tag gives `resp_valid` with `resp_hit`=1 and the cached byte on the cycle after acceptance, and issues no memory traffic.
- R4: A read miss raises `mem_rd_req` and, on the edge where `mem_rd_ack` is seen, installs `mem_rd_data` in the indexed line and returns the byte at the offset with `resp_hit`=0 on the next cycle.
- R5: A line is replaced by any fill to the same set with a different tag. With the default shape, reads of addresses 0, 1, 7, 8, 0 give miss, hit, miss, miss, miss.
- R6: Every write raises `mem_wr_req` with its address and byte until `mem_wr_ack`. On a hit the cached byte is also updated, so a later read hits and returns the new value.
- R7: A write miss allocates nothing: a later read of that address misses and fetches from memory.
- R8: From the cycle after a request that needs memory is accepted until its response, `req_ready` is 0. Read and write memory requests are never active together.
- R9: Each completed request increments exactly one counter, `hit_count` when `resp_hit`=1 and otherwise `miss_count`. The new count is visible in the same cycle as `resp_valid`.
- R10: A memory request and its address and data stay unchanged until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester presents a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request accepted when high with req_valid |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 8 | Read byte (reads only) |
| resp_hit | output | 1 | Completed request hit the cache |
| hit_count | output | CNT_W | Completed hits |
| miss_count | output | CNT_W | Completed misses |
| mem_rd_req | output | 1 | Block fill request |
| mem_rd_addr | output | ADDR_W | Block-aligned fill address |
| mem_rd_ack | input | 1 | Fill data valid |
| mem_rd_data | input | 8*2^OFF_W | Fill block |
| mem_wr_req | output | 1 | Byte write request |
| mem_wr_addr | output | ADDR_W | Write byte address |
| mem_wr_data | output | 8 | Write byte |
| mem_wr_ack | input | 1 | Write accepted |

## Verification
A wrong valid flag or a stale tag in a set shows up as a wrong `resp_hit` on the very next access to that set. It also shows as an extra or missing fill at the memory port, and as a counter step in the wrong counter in the same cycle. Corrupt line data appears as a wrong `resp_rdata` only when a later read hits that byte. For this reason the stimulus rereads written and refilled addresses, and it compares the memory image and the fill count at the end. A controller that fails to return to idle shows at once as `req_ready` stuck low.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int IDX_W = 2,
    parameter int TAG_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag
);
    localparam int NSETS = 1 << IDX_W;

    logic [NSETS-1:0] valid_q, valid_d;
    logic [TAG_W-1:0] tag_q [NSETS];
    logic [TAG_W-1:0] tag_d [NSETS];

    always_comb begin
        valid_d = valid_q;
        for (int i = 0; i < NSETS; i++) begin
            tag_d[i] = tag_q[i];
        end
        if (fill_en) begin
            valid_d[fill_idx] = 1'b1;
            tag_d[fill_idx]   = fill_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < NSETS; i++) begin
                tag_q[i] <= '0;
            end
        end else begin
            valid_q <= valid_d;
            for (int i = 0; i < NSETS; i++) begin
                tag_q[i] <= tag_d[i];
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    // R4: an installed line is valid with its new tag on the next cycle
    assert_fill_installs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (valid_q[$past(fill_idx)] && tag_q[$past(fill_idx)] == $past(fill_tag)));
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int IDX_W = 2,
    parameter int OFF_W = 1
) (
    input  logic                                 clk,
    input  logic [IDX_W-1:0]                     rd_idx,
    output logic [(8<<OFF_W)-1:0]                rd_line,
    input  logic                                 fill_en,
    input  logic [IDX_W-1:0]                     fill_idx,
    input  logic [(8<<OFF_W)-1:0]                fill_line,
    input  logic                                 byte_en,
    input  logic [IDX_W-1:0]                     byte_idx,
    input  logic [OFF_W-1:0]                     byte_off,
    input  logic [dmc_pkg::BYTE_W-1:0]           byte_data
);
    localparam int NSETS  = 1 << IDX_W;
    localparam int LINE_W = dmc_pkg::BYTE_W << OFF_W;

    logic [LINE_W-1:0] line_q [NSETS];
    logic [LINE_W-1:0] line_d [NSETS];

    always_comb begin
        for (int i = 0; i < NSETS; i++) begin
            line_d[i] = line_q[i];
        end
        if (fill_en) begin
            line_d[fill_idx] = fill_line;
        end
        if (byte_en) begin
            line_d[byte_idx][int'(byte_off)*dmc_pkg::BYTE_W +: dmc_pkg::BYTE_W] = byte_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NSETS; i++) begin
            line_q[i] <= line_d[i];
        end
    end

    assign rd_line = line_q[rd_idx];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 1,
    parameter int CNT_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [BYTE_W-1:0]             req_wdata,
    output logic                          req_ready,
    output logic                          resp_valid,
    output logic [BYTE_W-1:0]             resp_rdata,
    output logic                          resp_hit,
    output logic [CNT_W-1:0]              hit_count,
    output logic [CNT_W-1:0]              miss_count,
    output logic                          mem_rd_req,
    output logic [ADDR_W-1:0]             mem_rd_addr,
    input  logic                          mem_rd_ack,
    input  logic [(BYTE_W<<OFF_W)-1:0]    mem_rd_data,
    output logic                          mem_wr_req,
    output logic [ADDR_W-1:0]             mem_wr_addr,
    output logic [BYTE_W-1:0]             mem_wr_data,
    input  logic                          mem_wr_ack,
    output logic [IDX_W-1:0]              lk_idx,
    input  logic                          lk_valid,
    input  logic [ADDR_W-IDX_W-OFF_W-1:0] lk_tag,
    input  logic [(BYTE_W<<OFF_W)-1:0]    lk_line,
    output logic                          fill_en,
    output logic [IDX_W-1:0]              fill_idx,
    output logic [ADDR_W-IDX_W-OFF_W-1:0] fill_tag,
    output logic                          byte_en,
    output logic [OFF_W-1:0]              byte_off
);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = BYTE_W << OFF_W;

    typedef struct packed {
        dmc_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
        logic              hit;
        logic              rsp_v;
        logic [BYTE_W-1:0] rsp_d;
        logic              rsp_h;
        logic [CNT_W-1:0]  hits;
        logic [CNT_W-1:0]  misses;
    } ctrl_t;

    ctrl_t q, d;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [LINE_W-1:0] line,
                                                    input logic [OFF_W-1:0]  off);
        logic [LINE_W-1:0] sh;
        sh = line >> (int'(off) * BYTE_W);
        return sh[BYTE_W-1:0];
    endfunction

    logic [TAG_W-1:0] req_tag;
    logic [OFF_W-1:0] req_off;
    logic             lookup_hit;

    assign req_tag    = req_addr[ADDR_W-1 -: TAG_W];
    assign req_off    = req_addr[OFF_W-1:0];
    assign lk_idx     = req_addr[OFF_W +: IDX_W];
    assign lookup_hit = lk_valid && (lk_tag == req_tag);

    always_comb begin
        d          = q;
        d.rsp_v    = 1'b0;
        fill_en    = 1'b0;
        byte_en    = 1'b0;
        mem_rd_req = 1'b0;
        mem_wr_req = 1'b0;
        fill_idx   = q.addr[OFF_W +: IDX_W];
        fill_tag   = q.addr[ADDR_W-1 -: TAG_W];
        byte_off   = req_off;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.hit   = lookup_hit;
                    if (req_write) begin
                        byte_en = lookup_hit;
                        d.st    = ST_WRITE;
                    end else if (lookup_hit) begin
                        d.rsp_v = 1'b1;
                        d.rsp_d = pick_byte(lk_line, req_off);
                        d.rsp_h = 1'b1;
                        d.hits  = q.hits + 1'b1;
                    end else begin
                        d.st = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_rd_req = 1'b1;
                if (mem_rd_ack) begin
                    fill_en  = 1'b1;
                    d.rsp_v  = 1'b1;
                    d.rsp_d  = pick_byte(mem_rd_data, q.addr[OFF_W-1:0]);
                    d.rsp_h  = 1'b0;
                    d.misses = q.misses + 1'b1;
                    d.st     = ST_IDLE;
                end
            end
            ST_WRITE: begin
                mem_wr_req = 1'b1;
                if (mem_wr_ack) begin
                    d.rsp_v = 1'b1;
                    d.rsp_h = q.hit;
                    if (q.hit) begin
                        d.hits = q.hits + 1'b1;
                    end else begin
                        d.misses = q.misses + 1'b1;
                    end
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.addr   <= '0;
            q.wdata  <= '0;
            q.hit    <= 1'b0;
            q.rsp_v  <= 1'b0;
            q.rsp_d  <= '0;
            q.rsp_h  <= 1'b0;
            q.hits   <= '0;
            q.misses <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.st == ST_IDLE);
    assign resp_valid  = q.rsp_v;
    assign resp_rdata  = q.rsp_d;
    assign resp_hit    = q.rsp_h;
    assign hit_count   = q.hits;
    assign miss_count  = q.misses;
    assign mem_rd_addr = {q.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mem_wr_addr = q.addr;
    assign mem_wr_data = q.wdata;

    // R8: an accepted write or read miss blocks the requester next cycle
    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_write || !lookup_hit)) |=> !req_ready);

    // R8: one memory operation at a time
    assert_single_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    // R10: fill request held until acknowledged
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R10: write request held until acknowledged
    assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R1: fills are block aligned
    assert_fill_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[OFF_W-1:0] == '0));

    // R9: each response steps the counter total by exactly one
    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (CNT_W'(hit_count + miss_count) ==
                        CNT_W'($past(hit_count) + $past(miss_count) + 1'b1)));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int ADDR_W = 4,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 1,
    parameter int CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [7:0]               req_wdata,
    output logic                     req_ready,
    output logic                     resp_valid,
    output logic [7:0]               resp_rdata,
    output logic                     resp_hit,
    output logic [CNT_W-1:0]         hit_count,
    output logic [CNT_W-1:0]         miss_count,
    output logic                     mem_rd_req,
    output logic [ADDR_W-1:0]        mem_rd_addr,
    input  logic                     mem_rd_ack,
    input  logic [(8<<OFF_W)-1:0]    mem_rd_data,
    output logic                     mem_wr_req,
    output logic [ADDR_W-1:0]        mem_wr_addr,
    output logic [7:0]               mem_wr_data,
    input  logic                     mem_wr_ack
);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = 8 << OFF_W;

    logic [IDX_W-1:0]  lk_idx;
    logic              lk_valid;
    logic [TAG_W-1:0]  lk_tag;
    logic [LINE_W-1:0] lk_line;
    logic              fill_en;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;
    logic              byte_en;
    logic [OFF_W-1:0]  byte_off;

    dmc_ctrl #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_hit(resp_hit),
        .hit_count(hit_count), .miss_count(miss_count),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
        .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ack(mem_wr_ack),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_line(lk_line),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
        .byte_en(byte_en), .byte_off(byte_off)
    );

    dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_valid(lk_valid), .rd_tag(lk_tag),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag)
    );

    dmc_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
        .clk(clk),
        .rd_idx(lk_idx), .rd_line(lk_line),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_line(mem_rd_data),
        .byte_en(byte_en), .byte_idx(lk_idx), .byte_off(byte_off),
        .byte_data(req_wdata)
    );
endmodule

// File: tb/dmc_cache_bench.sv
module dmc_cache_bench;
    localparam int ADDR_W = 4;
    localparam int IDX_W  = 2;
    localparam int OFF_W  = 1;
    localparam int CNT_W  = 16;
    localparam int NBYTES = 1 << ADDR_W;
    localparam int NSETS  = 1 << IDX_W;
    localparam int BLK    = 1 << OFF_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic req_ready, resp_valid, resp_hit;
    logic [7:0] resp_rdata;
    logic [CNT_W-1:0] hit_count, miss_count;
    logic mem_rd_req, mem_wr_req;
    logic [ADDR_W-1:0] mem_rd_addr, mem_wr_addr;
    logic mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
    logic [8*BLK-1:0] mem_rd_data = '0;
    logic [7:0] mem_wr_data;

    always #5 clk = ~clk;

    dmc_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_dmc_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_hit(resp_hit),
        .hit_count(hit_count), .miss_count(miss_count),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
        .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ack(mem_wr_ack)
    );

    int tests = 0, fails = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory image seen by the bench memory model, and the reference copy
    logic [7:0] mem_m [NBYTES];
    logic [7:0] exp_mem [NBYTES];
    bit ref_v [NSETS];
    logic ref_t [NSETS];
    int lat = 0;
    int fills = 0, exp_fills = 0, wrs = 0, exp_wrs = 0;
    int exp_hits = 0, exp_miss = 0;
    logic [ADDR_W-1:0] cur_addr;
    bit last_hit;

    typedef struct { bit w; bit hit; logic [7:0] data; } exp_t;
    exp_t sb [$];

    // memory responder
    initial begin
        int wait_cnt = 0;
        for (int i = 0; i < NBYTES; i++) mem_m[i] = 8'(8'h31 + i * 7);
        forever begin
            @(negedge clk);
            if (mem_rd_ack) mem_rd_ack = 1'b0;
            else if (mem_wr_ack) mem_wr_ack = 1'b0;
            else if (mem_rd_req) begin
                if (wait_cnt >= lat) begin
                    wait_cnt = 0;
                    // R1: fill at block-aligned address of the current request
                    chk(mem_rd_addr == {cur_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}, "R1 fill address",
                        int'(mem_rd_addr), int'({cur_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}));
                    for (int k = 0; k < BLK; k++)
                        mem_rd_data[8*k +: 8] = mem_m[int'(mem_rd_addr) + k];
                    mem_rd_ack = 1'b1;
                    fills++;
                end else wait_cnt++;
            end else if (mem_wr_req) begin
                if (wait_cnt >= lat) begin
                    wait_cnt = 0;
                    // R6: write carries the request address and byte
                    chk(mem_wr_addr == cur_addr, "R6 write address", int'(mem_wr_addr), int'(cur_addr));
                    mem_m[mem_wr_addr] = mem_wr_data;
                    mem_wr_ack = 1'b1;
                    wrs++;
                end else wait_cnt++;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (resp_valid) begin
                if (sb.size() == 0) begin
                    chk(0, "R9 unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    last_hit = resp_hit;
                    chk(resp_hit == e.hit, "R3/R4/R7 hit flag", int'(resp_hit), int'(e.hit));
                    if (!e.w) chk(resp_rdata == e.data, "R3/R4/R6 read data", int'(resp_rdata), int'(e.data));
                    if (e.hit) exp_hits++; else exp_miss++;
                    chk(int'(hit_count) == exp_hits, "R9 hit_count", int'(hit_count), exp_hits);
                    chk(int'(miss_count) == exp_miss, "R9 miss_count", int'(miss_count), exp_miss);
                end
            end
        end
    end

    task automatic do_req(input bit w, input logic [ADDR_W-1:0] a, input logic [7:0] dat);
        exp_t e;
        int idx;
        logic tg;
        idx = int'(a[OFF_W +: IDX_W]);
        tg = a[ADDR_W-1];
        e.w = w;
        e.hit = ref_v[idx] && (ref_t[idx] == tg);
        e.data = exp_mem[a];
        if (w) begin
            exp_mem[a] = dat;
            exp_wrs++;
        end else if (!e.hit) begin
            ref_v[idx] = 1'b1;
            ref_t[idx] = tg;
            exp_fills++;
        end
        while (!req_ready) @(negedge clk);
        sb.push_back(e);
        cur_addr = a;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = dat;
        @(negedge clk);
        req_valid = 1'b0;
        if (w || !e.hit) chk(!req_ready, "R8 ready low while busy", int'(req_ready), 0);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        bit pat [5];
        logic [ADDR_W-1:0] tr [5];
        logic [7:0] rd_m;
        int s;
        tr[0] = 4'd0; tr[1] = 4'd1; tr[2] = 4'd7; tr[3] = 4'd8; tr[4] = 4'd0;
        pat[0] = 0; pat[1] = 1; pat[2] = 0; pat[3] = 0; pat[4] = 0;
        for (int i = 0; i < NSETS; i++) begin ref_v[i] = 0; ref_t[i] = 0; end
        #1;
        for (int i = 0; i < NBYTES; i++) exp_mem[i] = mem_m[i];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk(req_ready == 1'b1, "R2 ready after reset", int'(req_ready), 1);
        chk(hit_count == 0 && miss_count == 0, "R2 counters zero", int'(hit_count + miss_count), 0);
        chk(!mem_rd_req && !mem_wr_req, "R2 no memory request", int'(mem_rd_req), 0);

        // R5: conflict trace
        for (int i = 0; i < 5; i++) begin
            do_req(0, tr[i], 8'h00);
            drain();
            chk(last_hit == pat[i], "R5 trace hit pattern", int'(last_hit), int'(pat[i]));
        end
        // R3: back-to-back hits with slow memory
        lat = 2;
        do_req(0, 4'd1, 0); do_req(0, 4'd0, 0); do_req(0, 4'd6, 0);
        drain();
        // R6: write hit then read back
        do_req(1, 4'd1, 8'h5A); do_req(0, 4'd1, 0); drain();
        chk(last_hit == 1, "R6 read after write hit", int'(last_hit), 1);
        // R7: write miss to empty set 2, then read misses
        do_req(1, 4'd12, 8'hC3); drain();
        chk(last_hit == 0, "R7 write miss flag", int'(last_hit), 0);
        do_req(0, 4'd12, 0); drain();
        chk(last_hit == 0, "R7 read after write miss", int'(last_hit), 0);
        // R4: fill returns odd offset byte
        do_req(0, 4'd13, 0); drain();
        chk(last_hit == 1, "R4 neighbour byte from fill hits", int'(last_hit), 1);

        // mixed pattern with varying latency
        s = 17;
        for (int i = 0; i < 80; i++) begin
            s = (s * 1103 + 12345) % 65536;
            lat = (s >> 3) % 3;
            rd_m = 8'(s >> 5);
            do_req(((s >> 7) % 4) == 0, 4'(s >> 9), rd_m);
        end
        drain();
        repeat (4) @(negedge clk);

        chk(fills == exp_fills, "R3/R4 fill count", fills, exp_fills);
        chk(wrs == exp_wrs, "R6/R7 write count", wrs, exp_wrs);
        for (int i = 0; i < NBYTES; i++)
            chk(mem_m[i] == exp_mem[i], "R6 memory image", int'(mem_m[i]), int'(exp_mem[i]));
        finish_run();
    end
endmodule